// File: doc/BRIEF.md
# Master Clock Ratio Detector and Frame Resynchroniser

This block sits in the master-clock domain of an audio converter and watches the incoming frame clock and bit clock. It measures how many master-clock cycles separate successive rising frame edges and decides whether the master clock runs at 256 or 384 times the frame rate. It makes that decision without knowing the absolute sample rate. Once a ratio is settled, a free-running phase counter predicts where each frame edge should fall. Any frame edge that lands more than six bit-clock periods early or late starts a resynchronisation.

While power is coming up, the block runs an initialisation count and holds an internal reset low. The power-good level arrives as a single input. While the ratio is unknown, after a period that fits neither ratio, after a ratio change, after a phase slip or after a missing frame edge, the block drops its locked flag. It also raises a mute request that keeps the converter outputs at mid-scale. Mute is released on a frame boundary, one whole frame after lock has been reached.

Top module: `clk_ratio_guard`

## Requirements
- R1: While rst_n is low or pwr_good has not yet completed initialisation, int_rst_n is 0, locked is 0 and mute is 1.
- R2: int_rst_n rises on the clock edge at which pwr_good has been sampled high for 1024 consecutive master-clock edges. It falls one cycle after pwr_good is sampled low.
- R3: A frame period within ±4 master cycles of 256 is classed as the low ratio and reported as ratio_sel = 0. A period within ±4 of 384 is classed as the high ratio and reported as ratio_sel = 1.
- R4: locked rises only after two consecutive measured frame periods fall in the same ratio class.
- R5: mute is 1 whenever locked is 0. After lock, mute stays 1 through one full frame and falls just after the next rising frame edge.
- R6: A steady frame clock of exactly the locked ratio keeps locked at 1 and mute at 0 indefinitely.
- R7: A measured period of the other ratio class while locked clears locked and raises mute. The block then relocks with ratio_sel showing the new ratio.
- R8: A period that matches neither class clears locked. mute stays 1 for as long as such periods continue.
- R9: Frame periods that wander within ±4 cycles of nominal keep lock. A period 5 or more cycles away from nominal breaks lock.
- R10: While locked, a frame edge more than 6 bit-clock rising edges away from its predicted position starts resynchronisation. A slip of 6 or fewer keeps lock.
- R11: If no rising frame edge arrives within 388 master cycles of the previous one, locked is cleared and mute raised.
- R12: ratio_sel does not change while locked stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply-good level, synchronous to clk |
| frame_clk | input | 1 | Frame (left/right) clock, asynchronous |
| bit_clk | input | 1 | Serial bit clock, asynchronous |
| ratio_sel | output | 1 | Detected ratio: 0 = 256x, 1 = 384x |
| locked | output | 1 | Ratio and frame phase are locked |
| mute | output | 1 | Request to hold outputs at mid-scale |
| int_rst_n | output | 1 | Active-low internal reset for downstream logic |

## Verification
Some rules can be checked on every cycle. Mute must cover every unlocked cycle and the whole reset window. The internal reset must fall right after power-good drops and may rise only after a full initialisation count. The ratio must hold still while locked, and mute may fall only while locked. Other behaviours need a stimulus of many frames and only the directed scenarios can show them. These are the classification windows, the two-frame lock rule, the one-frame mute delay, ratio switching, slow phase drift past six bit clocks, and a stopped frame clock.

// File: rtl/crg_pkg.sv
package crg_pkg;
   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_LOW  = 2'd1,
      CLS_HIGH = 2'd2
   } ratio_cls_e;

   typedef enum logic [1:0] {
      ST_INIT = 2'd0,
      ST_ACQ  = 2'd1,
      ST_WAIT = 2'd2,
      ST_RUN  = 2'd3
   } seq_st_e;
endpackage

// File: rtl/crg_edge_sync.sv
module crg_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad
         $error("crg_edge_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];

   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/crg_period_meter.sv
module crg_period_meter
   import crg_pkg::*;
#(
   parameter int unsigned RATIO_LO = 256,
   parameter int unsigned RATIO_HI = 384,
   parameter int unsigned TOL      = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       frame_rise,
   output logic       meas_valid,
   output ratio_cls_e meas_cls,
   output logic       timeout
);
   localparam int unsigned LIMIT = RATIO_HI + TOL;
   localparam int unsigned CW    = $clog2(LIMIT + 2);
   localparam logic [CW-1:0] LO_MIN = CW'(RATIO_LO - TOL);
   localparam logic [CW-1:0] LO_MAX = CW'(RATIO_LO + TOL);
   localparam logic [CW-1:0] HI_MIN = CW'(RATIO_HI - TOL);
   localparam logic [CW-1:0] HI_MAX = CW'(LIMIT);

   logic [CW-1:0] cnt;
   logic          have;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cnt  <= '0;
         have <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         have <= 1'b0;
      end else if (frame_rise) begin
         cnt  <= CW'(1);
         have <= 1'b1;
      end else if (timeout) begin
         cnt  <= '0;
         have <= 1'b0;
      end else if (have) begin
         cnt  <= cnt + CW'(1);
      end

   assign timeout    = run && have && !frame_rise && (cnt == HI_MAX);
   assign meas_valid = run && have && frame_rise;

   always_comb begin
      if (cnt >= LO_MIN && cnt <= LO_MAX)      meas_cls = CLS_LOW;
      else if (cnt >= HI_MIN && cnt <= HI_MAX) meas_cls = CLS_HIGH;
      else                                     meas_cls = CLS_NONE;
   end
endmodule

// File: rtl/crg_phase_tracker.sv
module crg_phase_tracker #(
   parameter int unsigned RATIO_LO = 256,
   parameter int unsigned RATIO_HI = 384,
   parameter int unsigned PTOL     = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tracking,
   input  logic sel_hi,
   input  logic frame_rise,
   input  logic bit_rise,
   output logic drift
);
   localparam int unsigned CW = $clog2(RATIO_HI + 1);
   localparam int unsigned BW = $clog2(PTOL + 2);
   localparam logic [BW-1:0] SAT = BW'(PTOL + 1);
   localparam logic [BW-1:0] LIM = BW'(PTOL);

   logic [CW-1:0] nom, nom_m1, half, ph;
   logic [BW-1:0] late_bits, early_bits;
   logic          early_arm, at_wrap;

   assign nom     = sel_hi ? CW'(RATIO_HI) : CW'(RATIO_LO);
   assign nom_m1  = nom - CW'(1);
   assign half    = nom >> 1;
   assign at_wrap = (ph == '0);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ph         <= '0;
         late_bits  <= '0;
         early_bits <= '0;
         early_arm  <= 1'b0;
      end else begin
         if (frame_rise && !tracking) ph <= CW'(1);
         else if (ph >= nom_m1)       ph <= '0;
         else                         ph <= ph + CW'(1);

         if (at_wrap)                         late_bits <= bit_rise ? BW'(1) : '0;
         else if (bit_rise && late_bits != SAT) late_bits <= late_bits + BW'(1);

         if (!tracking) begin
            early_arm  <= 1'b0;
            early_bits <= '0;
         end else if (frame_rise && ph >= half) begin
            early_arm  <= 1'b1;
            early_bits <= '0;
         end else if (early_arm) begin
            if (at_wrap) early_arm <= 1'b0;
            if (bit_rise && early_bits != SAT) early_bits <= early_bits + BW'(1);
         end
      end

   assign drift = tracking &&
      ((frame_rise && !at_wrap && ph < half && late_bits > LIM) ||
       (early_arm && at_wrap && early_bits > LIM));
endmodule

// File: rtl/crg_sequencer.sv
module crg_sequencer
   import crg_pkg::*;
#(
   parameter int unsigned INIT_CYCLES = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_good,
   input  logic       meas_valid,
   input  ratio_cls_e meas_cls,
   input  logic       timeout,
   input  logic       drift,
   output seq_st_e    state,
   output logic       ratio_hi
);
   localparam int unsigned IW = $clog2(INIT_CYCLES);

   logic [IW-1:0] icnt;
   logic          good;
   ratio_cls_e    prev;
   ratio_cls_e    held_cls;
   logic          fault;

   assign held_cls = ratio_hi ? CLS_HIGH : CLS_LOW;
   assign fault    = timeout || drift || (meas_valid && meas_cls != held_cls);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state    <= ST_INIT;
         icnt     <= '0;
         good     <= 1'b0;
         prev     <= CLS_NONE;
         ratio_hi <= 1'b0;
      end else if (!pwr_good) begin
         state <= ST_INIT;
         icnt  <= '0;
         good  <= 1'b0;
      end else begin
         case (state)
            ST_INIT: begin
               if (icnt == IW'(INIT_CYCLES - 1)) begin
                  state <= ST_ACQ;
                  icnt  <= '0;
                  good  <= 1'b0;
               end else begin
                  icnt <= icnt + IW'(1);
               end
            end
            ST_ACQ: begin
               if (timeout) begin
                  good <= 1'b0;
               end else if (meas_valid) begin
                  if (meas_cls == CLS_NONE) begin
                     good <= 1'b0;
                  end else if (good && meas_cls == prev) begin
                     state    <= ST_WAIT;
                     ratio_hi <= (meas_cls == CLS_HIGH);
                     good     <= 1'b0;
                  end else begin
                     good <= 1'b1;
                     prev <= meas_cls;
                  end
               end
            end
            default: begin
               if (fault) begin
                  state <= ST_ACQ;
                  good  <= 1'b0;
               end else if (meas_valid && state == ST_WAIT) begin
                  state <= ST_RUN;
               end
            end
         endcase
      end
endmodule

// File: rtl/clk_ratio_guard.sv
module clk_ratio_guard
   import crg_pkg::*;
#(
   parameter int unsigned RATIO_LO    = 256,
   parameter int unsigned RATIO_HI    = 384,
   parameter int unsigned TOL         = 4,
   parameter int unsigned PTOL        = 6,
   parameter int unsigned INIT_CYCLES = 1024,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic frame_clk,
   input  logic bit_clk,
   output logic ratio_sel,
   output logic locked,
   output logic mute,
   output logic int_rst_n
);
   generate
      if (RATIO_HI <= RATIO_LO) begin : g_chk_order
         $error("RATIO_HI must exceed RATIO_LO");
      end
      if (2 * TOL >= RATIO_HI - RATIO_LO) begin : g_chk_tol
         $error("TOL windows of the two ratios overlap");
      end
      if (TOL >= RATIO_LO / 2) begin : g_chk_tol_lo
         $error("TOL too large for RATIO_LO");
      end
      if (INIT_CYCLES < 2) begin : g_chk_init
         $error("INIT_CYCLES must be at least 2");
      end
   endgenerate

   logic       frame_rise, bit_rise;
   logic       meas_valid, timeout, drift, tracking;
   ratio_cls_e meas_cls;
   seq_st_e    state;
   logic       ratio_hi;

   crg_edge_sync #(.STAGES(SYNC_STAGES)) u_frame_sync (
      .clk(clk), .rst_n(rst_n), .async_in(frame_clk), .rise(frame_rise));

   crg_edge_sync #(.STAGES(SYNC_STAGES)) u_bit_sync (
      .clk(clk), .rst_n(rst_n), .async_in(bit_clk), .rise(bit_rise));

   crg_period_meter #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI), .TOL(TOL)) u_meter (
      .clk(clk), .rst_n(rst_n), .run(state != ST_INIT), .frame_rise(frame_rise),
      .meas_valid(meas_valid), .meas_cls(meas_cls), .timeout(timeout));

   assign tracking = (state == ST_WAIT) || (state == ST_RUN);

   crg_phase_tracker #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI), .PTOL(PTOL)) u_phase (
      .clk(clk), .rst_n(rst_n), .tracking(tracking), .sel_hi(ratio_hi),
      .frame_rise(frame_rise), .bit_rise(bit_rise), .drift(drift));

   crg_sequencer #(.INIT_CYCLES(INIT_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .meas_valid(meas_valid),
      .meas_cls(meas_cls), .timeout(timeout), .drift(drift),
      .state(state), .ratio_hi(ratio_hi));

   assign ratio_sel = ratio_hi;
   assign locked    = tracking;
   assign mute      = (state != ST_RUN);
   assign int_rst_n = (state != ST_INIT);
endmodule

// File: rtl/clk_ratio_guard_chk.sv
module clk_ratio_guard_chk #(
   parameter int unsigned INIT_CYCLES = 1024
) (
   input logic clk,
   input logic rst_n,
   input logic pwr_good,
   input logic ratio_sel,
   input logic locked,
   input logic mute,
   input logic int_rst_n
);
   localparam int unsigned PW = $clog2(INIT_CYCLES + 1) + 1;
   logic [PW-1:0] pg_cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           pg_cnt <= '0;
      else if (!pwr_good)                   pg_cnt <= '0;
      else if (pg_cnt < PW'(INIT_CYCLES))   pg_cnt <= pg_cnt + PW'(1);

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !int_rst_n |-> (mute && !locked));

   assert_pg_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> !int_rst_n);

   assert_init_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_rst_n) |-> (pg_cnt >= PW'(INIT_CYCLES)));

   assert_mute_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> mute);

   assert_unmute_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mute) |-> locked);

   assert_ratio_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && $past(locked)) |-> $stable(ratio_sel));
endmodule

bind clk_ratio_guard clk_ratio_guard_chk #(.INIT_CYCLES(INIT_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ratio_sel(ratio_sel),
   .locked(locked), .mute(mute), .int_rst_n(int_rst_n));

// File: tb/sim_clk_ratio_guard.sv
`timescale 1ns/1ps
module sim_clk_ratio_guard;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b0;
   logic frame_i = 1'b0;
   logic bit_i = 1'b0;
   logic ratio_sel, locked, mute, int_rst_n;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 0;

   // frame generator state
   int pa = 256, pb = 256, bp = 4;
   bit gen_on = 1'b1;
   int fcnt = 0, bcnt = 0, cur = 256;
   bit alt = 1'b0;

   always #5 clk = ~clk;

   clk_ratio_guard u0 (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .frame_clk(frame_i),
      .bit_clk(bit_i), .ratio_sel(ratio_sel), .locked(locked), .mute(mute),
      .int_rst_n(int_rst_n));

   always @(negedge clk) begin
      cyc++;
      if (!gen_on) begin
         frame_i = 1'b0; bit_i = 1'b0; fcnt = 0; bcnt = 0;
      end else begin
         fcnt++; bcnt++;
         if (fcnt >= cur) begin
            fcnt = 0; bcnt = 0; alt = !alt; cur = alt ? pb : pa;
         end
         if (bcnt >= bp) bcnt = 0;
         frame_i = (fcnt < cur / 2);
         bit_i   = (bcnt < bp / 2);
      end
   end

   task automatic check(input string req, input int actual, input int expected, input string what);
      total++;
      if (actual != expected) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_lock(input logic want, input int max, output int seen);
      seen = 0;
      for (int i = 0; i < max; i++) begin
         @(negedge clk);
         if (locked == want) begin seen = 1; break; end
      end
   endtask

   // counts cycles with mute high and with locked low over a window
   task automatic watch(input int n, output int mute_hi, output int unlk);
      mute_hi = 0; unlk = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (mute) mute_hi++;
         if (!locked) unlk++;
      end
   endtask

   task automatic set_frames(input int p_a, input int p_b, input int bitp);
      pa = p_a; pb = p_b; bp = bitp;
   endtask

   task automatic t_reset;
      cycles(5);
      check("R1", mute, 1, "mute in reset");
      check("R1", locked, 0, "locked in reset");
      check("R1", int_rst_n, 0, "int_rst_n in reset");
      rst_n = 1'b1;
      cycles(20);
      check("R1", int_rst_n, 0, "int_rst_n without power-good");
      check("R1", mute, 1, "mute without power-good");
   endtask

   task automatic t_init;
      pwr_good = 1'b1;
      cycles(1023);
      check("R2", int_rst_n, 0, "int_rst_n one cycle before end of init");
      cycles(1);
      check("R2", int_rst_n, 1, "int_rst_n after 1024 cycles");
      check("R5", mute, 1, "mute right after init");
   endtask

   task automatic t_lock_low;
      int seen;
      wait_lock(1'b1, 2000, seen);
      check("R4", seen, 1, "lock reached at 256x");
      check("R3", ratio_sel, 0, "ratio_sel for 256x");
      cycles(100);
      check("R5", mute, 1, "mute held during frame after lock");
      cycles(300);
      check("R5", mute, 0, "mute released one frame after lock");
   endtask

   task automatic t_steady;
      int mh, ul;
      watch(256 * 20, mh, ul);
      check("R6", mh, 0, "mute cycles over 20 exact frames");
      check("R6", ul, 0, "unlocked cycles over 20 exact frames");
   endtask

   task automatic t_ratio_change;
      int seen;
      set_frames(384, 384, 6);
      wait_lock(1'b0, 1500, seen);
      check("R7", seen, 1, "lock lost on ratio change");
      check("R7", mute, 1, "mute on ratio change");
      wait_lock(1'b1, 3000, seen);
      check("R7", seen, 1, "relock at 384x");
      check("R3", ratio_sel, 1, "ratio_sel for 384x");
      cycles(900);
      check("R7", mute, 0, "mute released at 384x");
   endtask

   task automatic t_bad_period;
      int seen, mh, ul;
      set_frames(320, 320, 4);
      wait_lock(1'b0, 1500, seen);
      check("R8", seen, 1, "lock lost on 320-cycle period");
      watch(320 * 6, mh, ul);
      check("R8", mh, 320 * 6, "mute held while period is 320");
      check("R8", ul, 320 * 6, "unlocked while period is 320");
      set_frames(384, 384, 6);
      wait_lock(1'b1, 3000, seen);
      check("R8", seen, 1, "relock after good frames return");
      cycles(900);
      check("R8", mute, 0, "mute released after recovery");
   endtask

   task automatic t_tolerance;
      int seen, mh, ul;
      set_frames(388, 380, 6);
      watch(384 * 12, mh, ul);
      check("R9", mh, 0, "mute while period alternates 388/380");
      check("R9", ul, 0, "unlocked while period alternates 388/380");
      set_frames(389, 389, 6);
      wait_lock(1'b0, 1500, seen);
      check("R9", seen, 1, "lock lost at 389-cycle period");
      set_frames(384, 384, 6);
      wait_lock(1'b1, 3000, seen);
      check("R9", seen, 1, "relock at 384 after tolerance break");
      cycles(900);
   endtask

   task automatic t_drift;
      int seen, mh, ul;
      // 8 frames 3 cycles late each (24 cycles, 4 bit clocks), then back
      set_frames(387, 387, 6);
      cycles(387 * 8);
      set_frames(381, 381, 6);
      cycles(381 * 8);
      set_frames(384, 384, 6);
      watch(384 * 3, mh, ul);
      check("R10", ul, 0, "lock kept for slip within 6 bit clocks");
      check("R10", mh, 0, "mute low for slip within 6 bit clocks");
      set_frames(387, 387, 6);
      wait_lock(1'b0, 387 * 25, seen);
      check("R10", seen, 1, "resync after slip beyond 6 bit clocks");
      check("R10", mute, 1, "mute on phase resync");
      set_frames(384, 384, 6);
      wait_lock(1'b1, 3000, seen);
      cycles(900);
   endtask

   task automatic t_stop;
      int seen;
      check("R11", locked, 1, "locked before frame clock stops");
      gen_on = 1'b0;
      wait_lock(1'b0, 1000, seen);
      check("R11", seen, 1, "lock lost when frame clock stops");
      check("R11", mute, 1, "mute when frame clock stops");
      gen_on = 1'b1;
      wait_lock(1'b1, 3000, seen);
      check("R11", seen, 1, "relock after frame clock restarts");
   endtask

   task automatic t_power_drop;
      pwr_good = 1'b0;
      cycles(1);
      check("R2", int_rst_n, 0, "int_rst_n one cycle after power-good drop");
      check("R1", locked, 0, "locked after power-good drop");
      check("R1", mute, 1, "mute after power-good drop");
   endtask

   initial begin
      t_reset;
      t_init;
      t_lock_low;
      t_steady;
      t_ratio_change;
      t_bad_period;
      t_tolerance;
      t_drift;
      t_stop;
      t_power_drop;
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait (cyc >= 150000);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule